// File: doc/BRIEF.md
# Routed Five-Source Interrupt Controller

This block collects single-cycle event pulses from five timekeeping sources: a periodic tick, an alarm match, timer 0, timer 1 and a power-fail detector. Each pulse latches into a sticky pending bit. A pending bit reaches an output only when its enable bit is set and its route bit for that output is set. Two outputs exist. The primary line carries interrupts only. The auxiliary line carries interrupts by default, or can instead pass an oscillator-derived clock or the timer 0 output.

Each output has its own programmable polarity and drive mode (push-pull or open-drain). The pad is modelled as a level plus an output enable. While the system runs from backup power, both outputs are forced into open-drain mode whatever the drive-mode bits say.

A host reaches every register through a synchronous write strobe and a combinational read mux. Pending bits are cleared by writing ones to them.

Top module: `irq_router`

## Requirements
- R1: After reset, every register reads 0. Both outputs are then active-low and push-pull, so each drives level 1 with its output enable at 1.
- R2: An event pulse on bit i of `evt_i` sets pending bit i at the next clock edge. The bit stays set until it is cleared. Source bit order is: 0 periodic, 1 alarm, 2 timer 0, 3 timer 1, 4 power fail.
- R3: A write to address 0 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left as they were.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends set.
- R5: An output is asserted only while some source has its pending bit, its enable bit (address 1) and its route bit for that output all set.
- R6: The routing masks are independent. Address 2 routes sources to the primary output and address 3 routes them to the auxiliary output.
- R7: Config register (address 4) bit 0 selects the primary polarity and bit 2 selects the auxiliary polarity: 1 means asserted is high, 0 means asserted is low.
- R8: Config bit 1 puts the primary output in open-drain mode and bit 3 does the same for the auxiliary output. In open-drain mode the output enable is the inverse of the level. In push-pull mode the enable is 1.
- R9: While `on_battery_i` is 1, both outputs behave as open-drain, regardless of config bits 1 and 3.
- R10: Config bits 5:4 select the auxiliary function: 0 or 3 routed interrupt, 1 the `osc_i` signal, 2 the `tmr0_out_i` signal. The auxiliary polarity bit applies in every mode.
- R11: Registers read back on `rdata_o` at their addresses. The 5-bit registers drop written bits above bit 4, the config register keeps bits 5:0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Event pulses, one bit per source |
| osc_i | input | 1 | Oscillator-derived clock for the auxiliary output |
| tmr0_out_i | input | 1 | Timer 0 output for the auxiliary output |
| on_battery_i | input | 1 | Backup-power indication, forces open-drain |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational on `addr_i` |
| main_lvl_o | output | 1 | Primary output level |
| main_oe_o | output | 1 | Primary output enable |
| aux_lvl_o | output | 1 | Auxiliary output level |
| aux_oe_o | output | 1 | Auxiliary output enable |

## Verification
Nothing in the output path is stored, so a corrupted pending, enable or route bit shows on the output level within the same cycle it arises. This happens only if the other two gating terms for that source are open, which is why the stimulus opens different source/output combinations in turn. A pending bit that fails to set or clear also shows at once through the address-0 readback. A wrong drive-mode decision shows as an enable that is not the inverse of the level while in open-drain, checked both with the config bit and with the backup-power override.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int CFGW = 6;

  localparam logic [AW-1:0] A_PEND   = 3'd0;
  localparam logic [AW-1:0] A_ENABLE = 3'd1;
  localparam logic [AW-1:0] A_RT_PRI = 3'd2;
  localparam logic [AW-1:0] A_RT_AUX = 3'd3;
  localparam logic [AW-1:0] A_CFG    = 3'd4;

  localparam int C_PRI_HI = 0;
  localparam int C_PRI_OD = 1;
  localparam int C_AUX_HI = 2;
  localparam int C_AUX_OD = 3;
  localparam int C_AUX_FN = 4;

  typedef enum logic [1:0] {
    AUXF_IRQ  = 2'd0,
    AUXF_OSC  = 2'd1,
    AUXF_TMR0 = 2'd2,
    AUXF_IRQB = 2'd3
  } aux_fn_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            clr_we_i,
  input  logic            ena_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] ena_o
);
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] ena_q, ena_d;

  always_comb begin
    pend_d = pend_q;
    ena_d  = ena_q;
    for (int i = 0; i < NSRC; i++) begin
      if (clr_we_i && wdata_i[i]) pend_d[i] = 1'b0;
      if (evt_i[i])               pend_d[i] = 1'b1;
    end
    if (ena_we_i) ena_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ena_q  <= ena_d;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC = 5,
  parameter int CFGW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rt_pri_we_i,
  input  logic            rt_aux_we_i,
  input  logic            cfg_we_i,
  input  logic [NSRC-1:0] rt_wdata_i,
  input  logic [CFGW-1:0] cfg_wdata_i,
  output logic [NSRC-1:0] rt_pri_o,
  output logic [NSRC-1:0] rt_aux_o,
  output logic [CFGW-1:0] cfg_o
);
  logic [NSRC-1:0] rt_pri_q, rt_pri_d, rt_aux_q, rt_aux_d;
  logic [CFGW-1:0] cfg_q, cfg_d;

  always_comb begin
    rt_pri_d = rt_pri_we_i ? rt_wdata_i  : rt_pri_q;
    rt_aux_d = rt_aux_we_i ? rt_wdata_i  : rt_aux_q;
    cfg_d    = cfg_we_i    ? cfg_wdata_i : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_pri_q <= '0;
      rt_aux_q <= '0;
      cfg_q    <= '0;
    end else begin
      rt_pri_q <= rt_pri_d;
      rt_aux_q <= rt_aux_d;
      cfg_q    <= cfg_d;
    end
  end

  assign rt_pri_o = rt_pri_q;
  assign rt_aux_o = rt_aux_q;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NSRC = 5
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] ena_i,
  input  logic [NSRC-1:0] route_i,
  input  logic            active_hi_i,
  input  logic            open_drain_i,
  input  logic            force_od_i,
  input  logic            alt_en_i,
  input  logic            alt_val_i,
  output logic            lvl_o,
  output logic            oe_o
);
  logic hit;
  logic asserted;
  logic od_mode;

  always_comb begin
    hit      = |(pend_i & ena_i & route_i);
    asserted = alt_en_i ? alt_val_i : hit;
    lvl_o    = active_hi_i ? asserted : ~asserted;
    od_mode  = open_drain_i | force_od_i;
    oe_o     = od_mode ? ~lvl_o : 1'b1;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [4:0]    evt_i,
  input  logic          osc_i,
  input  logic          tmr0_out_i,
  input  logic          on_battery_i,
  input  logic          wr_en_i,
  input  logic [2:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          main_lvl_o,
  output logic          main_oe_o,
  output logic          aux_lvl_o,
  output logic          aux_oe_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n_int;
  logic [NSRC-1:0] pend, ena, rt_pri, rt_aux;
  logic [CFGW-1:0] cfg;
  logic            we_pend, we_ena, we_rtp, we_rta, we_cfg;
  aux_fn_e         aux_fn;
  logic            aux_alt_en, aux_alt_val;
  logic            unused_wbits;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    we_pend = wr_en_i && (addr_i == A_PEND);
    we_ena  = wr_en_i && (addr_i == A_ENABLE);
    we_rtp  = wr_en_i && (addr_i == A_RT_PRI);
    we_rta  = wr_en_i && (addr_i == A_RT_AUX);
    we_cfg  = wr_en_i && (addr_i == A_CFG);
  end
  assign unused_wbits = ^wdata_i[DW-1:CFGW];

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .evt_i    (evt_i),
    .clr_we_i (we_pend),
    .ena_we_i (we_ena),
    .wdata_i  (wdata_i[NSRC-1:0]),
    .pend_o   (pend),
    .ena_o    (ena)
  );

  irq_cfg_regs #(.NSRC(NSRC), .CFGW(CFGW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .rt_pri_we_i (we_rtp),
    .rt_aux_we_i (we_rta),
    .cfg_we_i    (we_cfg),
    .rt_wdata_i  (wdata_i[NSRC-1:0]),
    .cfg_wdata_i (wdata_i[CFGW-1:0]),
    .rt_pri_o    (rt_pri),
    .rt_aux_o    (rt_aux),
    .cfg_o       (cfg)
  );

  always_comb begin
    aux_fn = aux_fn_e'(cfg[C_AUX_FN +: 2]);
    unique case (aux_fn)
      AUXF_OSC:  begin aux_alt_en = 1'b1; aux_alt_val = osc_i;      end
      AUXF_TMR0: begin aux_alt_en = 1'b1; aux_alt_val = tmr0_out_i; end
      default:   begin aux_alt_en = 1'b0; aux_alt_val = 1'b0;       end
    endcase
  end

  irq_out_stage #(.NSRC(NSRC)) u_pri (
    .pend_i       (pend),
    .ena_i        (ena),
    .route_i      (rt_pri),
    .active_hi_i  (cfg[C_PRI_HI]),
    .open_drain_i (cfg[C_PRI_OD]),
    .force_od_i   (on_battery_i),
    .alt_en_i     (1'b0),
    .alt_val_i    (1'b0),
    .lvl_o        (main_lvl_o),
    .oe_o         (main_oe_o)
  );

  irq_out_stage #(.NSRC(NSRC)) u_aux (
    .pend_i       (pend),
    .ena_i        (ena),
    .route_i      (rt_aux),
    .active_hi_i  (cfg[C_AUX_HI]),
    .open_drain_i (cfg[C_AUX_OD]),
    .force_od_i   (on_battery_i),
    .alt_en_i     (aux_alt_en),
    .alt_val_i    (aux_alt_val),
    .lvl_o        (aux_lvl_o),
    .oe_o         (aux_oe_o)
  );

  always_comb begin
    unique case (addr_i)
      A_PEND:   rdata_o = DW'(pend);
      A_ENABLE: rdata_o = DW'(ena);
      A_RT_PRI: rdata_o = DW'(rt_pri);
      A_RT_AUX: rdata_o = DW'(rt_aux);
      A_CFG:    rdata_o = DW'(cfg);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk (
  input logic       clk_i,
  input logic       rst_n_int,
  input logic [4:0] evt_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       on_battery_i,
  input logic [4:0] pend,
  input logic [4:0] ena,
  input logic [4:0] rt_pri,
  input logic [5:0] cfg,
  input logic       main_lvl_o,
  input logic       main_oe_o,
  input logic       aux_lvl_o,
  input logic       aux_oe_o
);
  // R2 and R4: a pulsed source is pending on the next cycle, whatever the host wrote.
  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (evt_i != 5'd0) |=> ((pend & $past(evt_i)) == $past(evt_i)));

  // R3: without a clearing write, no pending bit falls.
  p_no_spont_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !(wr_en_i && addr_i == 3'd0) |=> ((pend & $past(pend)) == $past(pend)));

  // R3: a write of zeros to the pending register keeps every bit.
  p_zero_write_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (wr_en_i && addr_i == 3'd0 && wdata_i[4:0] == 5'd0) |=> ((pend & $past(pend)) == $past(pend)));

  // R5: nothing gated through means the primary sits at its idle level.
  p_idle_when_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ((pend & ena & rt_pri) == 5'd0) |-> (main_lvl_o == ~cfg[0]));

  // R8: open-drain mode ties the enable to the inverse of the level.
  p_od_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    cfg[1] |-> (main_oe_o == ~main_lvl_o));

  // R8: push-pull mode always drives.
  p_pp_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!cfg[1] && !on_battery_i) |-> main_oe_o);

  // R9: backup power forces both outputs to open-drain.
  p_battery_od_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    on_battery_i |-> ((main_oe_o == ~main_lvl_o) && (aux_oe_o == ~aux_lvl_o)));
endmodule

bind irq_router irq_router_chk i_chk (
  .clk_i        (clk_i),
  .rst_n_int    (rst_n_int),
  .evt_i        (evt_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .on_battery_i (on_battery_i),
  .pend         (pend),
  .ena          (ena),
  .rt_pri       (rt_pri),
  .cfg          (cfg),
  .main_lvl_o   (main_lvl_o),
  .main_oe_o    (main_oe_o),
  .aux_lvl_o    (aux_lvl_o),
  .aux_oe_o     (aux_oe_o)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // Row layout: wr(1) addr(3) wdata(8) evt(5) exp_main(1) exp_aux(1).
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 8'h1F, 5'h00, 1'b1, 1'b1},
    {1'b1, 3'd2, 8'h03, 5'h00, 1'b1, 1'b1},
    {1'b1, 3'd3, 8'h1C, 5'h00, 1'b1, 1'b1},
    {1'b0, 3'd0, 8'h00, 5'h01, 1'b0, 1'b1},
    {1'b1, 3'd0, 8'h01, 5'h00, 1'b1, 1'b1},
    {1'b0, 3'd0, 8'h00, 5'h08, 1'b1, 1'b0},
    {1'b1, 3'd1, 8'h17, 5'h00, 1'b1, 1'b1},
    {1'b1, 3'd1, 8'h1F, 5'h00, 1'b1, 1'b0},
    {1'b1, 3'd0, 8'h08, 5'h00, 1'b1, 1'b1},
    {1'b1, 3'd4, 8'h05, 5'h00, 1'b0, 1'b0},
    {1'b0, 3'd0, 8'h00, 5'h12, 1'b1, 1'b1},
    {1'b1, 3'd0, 8'h02, 5'h00, 1'b0, 1'b1},
    {1'b1, 3'd0, 8'h10, 5'h00, 1'b0, 1'b0},
    {1'b1, 3'd2, 8'h1F, 5'h04, 1'b1, 1'b1},
    {1'b1, 3'd0, 8'h04, 5'h00, 1'b0, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [4:0] evt_i;
  logic       osc_i, tmr0_out_i, on_battery_i, wr_en_i;
  logic [2:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       main_lvl_o, main_oe_o, aux_lvl_o, aux_oe_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_router i_irq_router (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .osc_i(osc_i),
    .tmr0_out_i(tmr0_out_i), .on_battery_i(on_battery_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .main_lvl_o(main_lvl_o), .main_oe_o(main_oe_o),
    .aux_lvl_o(aux_lvl_o), .aux_oe_o(aux_oe_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [7:0] d, input logic [4:0] e);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = d; evt_i = e;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; evt_i = 5'h00;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  initial begin
    rst_ni = 1'b0; evt_i = '0; osc_i = 1'b0; tmr0_out_i = 1'b0;
    on_battery_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R1 reg after reset");
    check("R1 main lvl/oe", {6'd0, main_lvl_o, main_oe_o}, 8'h03);
    check("R1 aux lvl/oe",  {6'd0, aux_lvl_o, aux_oe_o},   8'h03);

    // R2 R5 R6 R7: table walk
    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][18], VEC[k][17:15], VEC[k][14:7], VEC[k][6:2]);
      check("R5/R6/R7 table main", {7'd0, main_lvl_o}, {7'd0, VEC[k][1]});
      check("R5/R6/R7 table aux",  {7'd0, aux_lvl_o},  {7'd0, VEC[k][0]});
    end

    // R2 then R3: zero write keeps, one write clears
    step(1'b0, 3'd0, 8'h00, 5'h03);
    rd(3'd0, 8'h03, "R2 pend set");
    step(1'b1, 3'd0, 8'h00, 5'h00);
    rd(3'd0, 8'h03, "R3 zero write keeps");
    step(1'b1, 3'd0, 8'h01, 5'h00);
    rd(3'd0, 8'h02, "R3 one write clears");

    // R4: set wins over coincident clear
    step(1'b1, 3'd0, 8'h04, 5'h04);
    rd(3'd0, 8'h06, "R4 set wins");

    // R8: primary open-drain, active-low
    step(1'b1, 3'd4, 8'h02, 5'h00);
    check("R8 od asserted", {6'd0, main_lvl_o, main_oe_o}, 8'h01);
    check("R8 aux pp asserted", {6'd0, aux_lvl_o, aux_oe_o}, 8'h01);
    step(1'b1, 3'd0, 8'h1F, 5'h00);
    check("R8 od released", {6'd0, main_lvl_o, main_oe_o}, 8'h02);

    // R9: battery forces open-drain
    step(1'b1, 3'd4, 8'h00, 5'h00);
    on_battery_i = 1'b1;
    #1;
    check("R9 main forced od", {6'd0, main_lvl_o, main_oe_o}, 8'h02);
    check("R9 aux forced od",  {6'd0, aux_lvl_o, aux_oe_o},   8'h02);
    on_battery_i = 1'b0;
    #1;
    check("R9 released", {6'd0, main_oe_o, aux_oe_o}, 8'h03);

    // R10: auxiliary alternate functions
    step(1'b1, 3'd4, 8'h10, 5'h00);
    osc_i = 1'b1; #1;
    check("R10 osc active-low", {7'd0, aux_lvl_o}, 8'h00);
    step(1'b1, 3'd4, 8'h14, 5'h00);
    check("R10 osc active-high hi", {7'd0, aux_lvl_o}, 8'h01);
    osc_i = 1'b0; #1;
    check("R10 osc active-high lo", {7'd0, aux_lvl_o}, 8'h00);
    step(1'b1, 3'd4, 8'h24, 5'h00);
    tmr0_out_i = 1'b1; #1;
    check("R10 tmr0 hi", {7'd0, aux_lvl_o}, 8'h01);
    tmr0_out_i = 1'b0; #1;
    check("R10 tmr0 lo", {7'd0, aux_lvl_o}, 8'h00);

    // R11: readback widths and unmapped address
    step(1'b1, 3'd3, 8'h15, 5'h00);
    rd(3'd3, 8'h15, "R11 aux route readback");
    step(1'b1, 3'd1, 8'hFF, 5'h00);
    rd(3'd1, 8'h1F, "R11 enable width");
    step(1'b1, 3'd4, 8'hFF, 5'h00);
    rd(3'd4, 8'h3F, "R11 cfg width");
    rd(3'd5, 8'h00, "R11 unmapped");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule